// File: doc/BRIEF.md
# Serial Line Code Encoder

This block turns a synchronous serial bit stream into one of four line codes chosen by a 2-bit select: plain level (NRZ), transition-on-one (NRZI), return-to-zero (RZ), or Manchester. It runs on a clock at twice the bit rate, so every bit period is split into a first and a second half-bit slot. A strobe marks the first slot of each bit. The data bit is captured on that strobe and held for the whole bit.

The line output comes straight from a register, so it changes only on clock edges and never follows the inputs combinationally. The bit sampled with the strobe appears on `line_out` one clock after the edge that samples it. The line runs at a fixed rate and has no way to stall. For that reason the data input carries no valid/ready pair and there is no back-pressure. The strobe alone says when a bit is taken, and a new bit must be offered every two clocks.

The select is sampled on every clock, so a change of code takes effect on the next slot. The NRZI running level is stored separately. It moves only while NRZI is selected.

Top module: `line_code_encoder`

## Requirements
- R1: While `rst_n` is low, `line_out` is 0 and the stored NRZI level is cleared to 0. After reset, the first NRZI bit of 1 therefore drives the line high.
- R2: With `code_sel` = 2'b00 (NRZ), `line_out` equals the held data bit in both half-bit slots.
- R3: With `code_sel` = 2'b01 (NRZI), a held bit of 0 repeats the previously transmitted NRZI level for both slots.
- R4: With `code_sel` = 2'b01 (NRZI), a held bit of 1 sends the complement of the previously transmitted NRZI level for both slots.
- R5: With `code_sel` = 2'b10 (RZ), a held bit of 0 gives a low line in both slots.
- R6: With `code_sel` = 2'b10 (RZ), a held bit of 1 gives high in the first slot and low in the second slot.
- R7: With `code_sel` = 2'b11 (Manchester), a 0 is sent as low then high and a 1 as high then low, so the line always changes between the two slots of a bit.
- R8: `bit_in` is sampled only at a clock edge where `bit_strobe` is 1. Changes on `bit_in` at other edges have no effect on `line_out`.
- R9: `line_out` is registered. The first-slot value of a bit appears one clock after the edge that samples the strobe. The second-slot value appears one clock later.
- R10: If no strobe arrives after the second slot, the encoder stays in the second-slot value of the held bit until the next strobe.
- R11: The NRZI level changes only on a strobe while NRZI is selected. Bits sent in other codes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_in | input | 1 | Serial data bit, sampled with the strobe |
| bit_strobe | input | 1 | High for the first half-bit slot of each bit |
| code_sel | input | 2 | Line code: 00 NRZ, 01 NRZI, 10 RZ, 11 Manchester |
| line_out | output | 1 | Registered encoded line signal |

## Verification
The same bit string, 0010_1001, is sent in each of the four codes. Its runs of zeros and ones separate NRZ from NRZI. Its lone ones show the half-bit return of RZ, and its mixed bits expose a swapped Manchester phase. Some bits have `bit_in` flipped during their second slot, which catches an encoder that samples without the strobe. Stretched gaps with no strobe check how the second slot is held. NRZ and RZ bits are placed between NRZI runs to show that the running NRZI level survives a change of code.

// File: rtl/line_code_pkg.sv
package line_code_pkg;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    CODE_NRZ  = 2'b00,
    CODE_NRZI = 2'b01,
    CODE_RZ   = 2'b10,
    CODE_MAN  = 2'b11
  } code_e;
endpackage

// File: rtl/bit_slot_tracker.sv
module bit_slot_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_in,
  input  logic bit_strobe,
  output logic held_bit_n,
  output logic first_slot_n
);
  logic held_q;

  always_comb begin
    held_bit_n   = bit_strobe ? bit_in : held_q;
    first_slot_n = bit_strobe;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) held_q <= 1'b0;
    else        held_q <= held_bit_n;
  end

  // R8: without a strobe the held bit does not move
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_strobe && $past(rst_n)) |=> $stable(held_q));
endmodule

// File: rtl/nrzi_level.sv
module nrzi_level
  import line_code_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_in,
  input  logic       bit_strobe,
  input  logic [SEL_W-1:0] code_sel,
  output logic       level_n
);
  logic level_q;
  logic step;

  always_comb begin
    step    = bit_strobe && (code_sel == CODE_NRZI) && bit_in;
    level_n = level_q ^ step;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_n;
  end

  // R4: a strobed 1 in NRZI flips the level
  a_r4_nrzi_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_strobe && bit_in && code_sel == CODE_NRZI) |=> (level_q != $past(level_q)));
  // R11: other codes leave the level alone
  a_r11_level_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (code_sel != CODE_NRZI && $past(rst_n)) |=> $stable(level_q));
endmodule

// File: rtl/code_mapper.sv
module code_mapper
  import line_code_pkg::*;
(
  input  logic             held_bit,
  input  logic             first_slot,
  input  logic             level,
  input  logic [SEL_W-1:0] code_sel,
  output logic             line_n
);
  always_comb begin
    unique case (code_e'(code_sel))
      CODE_NRZ:  line_n = held_bit;
      CODE_NRZI: line_n = level;
      CODE_RZ:   line_n = held_bit & first_slot;
      CODE_MAN:  line_n = first_slot ? held_bit : ~held_bit;
      default:   line_n = 1'b0;
    endcase
  end
endmodule

// File: rtl/line_code_encoder.sv
module line_code_encoder
  import line_code_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_in,
  input  logic             bit_strobe,
  input  logic [SEL_W-1:0] code_sel,
  output logic             line_out
);
  logic held_bit_n;
  logic first_slot_n;
  logic level_n;
  logic line_n;

  bit_slot_tracker slot_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_in       (bit_in),
    .bit_strobe   (bit_strobe),
    .held_bit_n   (held_bit_n),
    .first_slot_n (first_slot_n)
  );

  nrzi_level nrzi_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_in     (bit_in),
    .bit_strobe (bit_strobe),
    .code_sel   (code_sel),
    .level_n    (level_n)
  );

  code_mapper map_i (
    .held_bit   (held_bit_n),
    .first_slot (first_slot_n),
    .level      (level_n),
    .code_sel   (code_sel),
    .line_n     (line_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) line_out <= 1'b0;
    else        line_out <= line_n;
  end

  // R1: reset forces a low line
  a_r1_reset_low: assert property (@(posedge clk)
    $past(rst_n) == 1'b0 && $past(rst_n, 2) == 1'b0 |-> !line_out);
  // R2 / R9: NRZ first slot mirrors the strobed bit one clock later
  a_r2_nrz_follow: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(code_sel) == CODE_NRZ && $past(bit_strobe)) |-> (line_out == $past(bit_in)));
  // R6 / R5: RZ is always low outside the first slot
  a_r6_rz_second_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(code_sel) == CODE_RZ && !$past(bit_strobe)) |-> !line_out);
  // R7: Manchester toggles at mid-bit
  a_r7_mid_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && $past(rst_n) && $past(code_sel) == CODE_MAN &&
     $past(code_sel, 2) == CODE_MAN && $past(bit_strobe, 2) && !$past(bit_strobe))
    |-> (line_out != $past(line_out)));
endmodule

// File: tb/line_code_encoder_tb_top.sv
module line_code_encoder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_in = 1'b0;
  logic       bit_strobe = 1'b0;
  logic [1:0] code_sel = 2'b00;
  logic       line_out;

  int checks = 0;
  int fails  = 0;

  // reference state
  logic m_bit = 1'b0;
  logic m_first = 1'b0;
  logic m_lvl = 1'b0;

  always #2.5 clk = ~clk;

  line_code_encoder dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_in     (bit_in),
    .bit_strobe (bit_strobe),
    .code_sel   (code_sel),
    .line_out   (line_out)
  );

  task automatic check(input logic exp, input string tag);
    checks++;
    if (line_out !== exp) begin
      fails++;
      $display("FAIL %s: line_out=%b expected=%b at %0t", tag, line_out, exp, $time);
    end
  endtask

  // drive one clock of inputs, predict the registered output, check it
  task automatic cycle(input logic s, input logic d, input logic [1:0] m, input string tag_in);
    logic  exp;
    string tag;
    bit_strobe = s;
    bit_in     = d;
    code_sel   = m;
    if (s) begin
      m_bit   = d;
      m_first = 1'b1;
      if (m == 2'b01) m_lvl = m_lvl ^ d;
    end else begin
      m_first = 1'b0;
    end
    case (m)
      2'b00: begin exp = m_bit; tag = "R2"; end
      2'b01: begin exp = m_lvl; tag = m_bit ? "R4" : "R3"; end
      2'b10: begin exp = m_bit && m_first; tag = m_bit ? "R6" : "R5"; end
      default: begin exp = m_first ? m_bit : !m_bit; tag = "R7"; end
    endcase
    if (tag_in != "") tag = {tag_in, "/", tag};
    @(negedge clk);
    check(exp, tag);
  endtask

  // one bit: strobe slot then a second slot where bit_in is flipped (R8)
  task automatic send_bit(input logic d, input logic [1:0] m, input int extra);
    cycle(1'b1, d, m, "R9");
    cycle(1'b0, !d, m, "R8");
    for (int k = 0; k < extra; k++) cycle(1'b0, k[0], m, "R10");
  endtask

  task automatic send_pattern(input logic [7:0] p, input logic [1:0] m);
    for (int i = 7; i >= 0; i--) send_bit(p[i], m, 0);
  endtask

  initial begin
    #200000;
    fails++;
    checks++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    bit_strobe = 1'b1;
    bit_in     = 1'b1;
    @(negedge clk);
    check(1'b0, "R1");
    @(negedge clk);
    check(1'b0, "R1");
    bit_strobe = 1'b0;
    rst_n = 1'b1;
    // R1: cleared NRZI level, first 1 drives high
    cycle(1'b1, 1'b1, 2'b01, "R1");
    cycle(1'b0, 1'b1, 2'b01, "R1");

    send_pattern(8'b0010_1001, 2'b00);
    send_pattern(8'b0010_1001, 2'b01);
    send_pattern(8'b0010_1001, 2'b10);
    send_pattern(8'b0010_1001, 2'b11);
    send_pattern(8'b1111_0000, 2'b11);

    // R10: stretched gaps
    send_bit(1'b1, 2'b11, 3);
    send_bit(1'b0, 2'b11, 2);
    send_bit(1'b1, 2'b10, 3);
    send_bit(1'b1, 2'b00, 2);

    // R11: NRZI level survives other codes
    send_bit(1'b1, 2'b01, 0);
    send_bit(1'b1, 2'b10, 0);
    send_bit(1'b1, 2'b11, 0);
    send_bit(1'b0, 2'b00, 0);
    cycle(1'b1, 1'b0, 2'b01, "R11");
    cycle(1'b0, 1'b1, 2'b01, "R11");
    cycle(1'b1, 1'b1, 2'b01, "R11");
    cycle(1'b0, 1'b0, 2'b01, "R11");

    // code change mid-bit takes effect on the next slot
    cycle(1'b1, 1'b1, 2'b10, "R9");
    cycle(1'b0, 1'b1, 2'b11, "R9");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule